// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port

This block controls one 8-bit bidirectional port of a device that pairs a microcontroller with programmable logic. Each pin can present one of three values. It can show a bit of a data register that the microcontroller writes. It can show a bit of the low address byte, which a transparent latch captures while the address strobe is high. It can also show a programmable-logic output, when the neighbouring logic routes its bank of eight outputs to this port. The output enable follows a source that matches the value source. That source is a microcontroller-written direction register, a fixed enable in address mode, or an enable vector driven by the logic.

The four upper pins can each be placed in open-drain mode. Such a pin pulls low only when its value is 0 and floats otherwise. A combinational read path returns either the live pin levels or any stored register to the microcontroller. The pin levels also pass straight through to the logic-side input cells. The pad is modelled as separate value, enable and input vectors, so no tri-state primitive is needed.

Top module: `cfg_io_port`

## Requirements
- R1: A synchronous reset clears the value register, the direction register, the source-select register, the open-drain register and the address latch. After reset, with routing off, no pin drives and every register reads 0.
- R2: On a rising edge with `wr_en` high, the register named by `wr_sel` takes `wr_data`: 0 value, 1 direction, 2 source select, 3 open-drain. With `wr_en` low no register changes.
- R3: With routing off and source-select bit i at 0, `pin_out[i]` equals value-register bit i and `pin_oe[i]` equals direction bit i.
- R4: With routing off and source-select bit i at 1, `pin_out[i]` equals latched address bit i and `pin_oe[i]` is 1.
- R5: The address latch follows `addr_lo` while `ale` is high and keeps its last value while `ale` is low.
- R6: With `mc_here` high, every pin takes `mc_out` as its value and `pt_oe` as its enable, whatever the source-select bits hold.
- R7: Open-drain register bits 7 to 4 are writable and bits 3 to 0 always read 0. For a pin in open-drain mode, `pin_out` is 0 and `pin_oe` is 1 only when the selected value is 0 and the selected enable is 1.
- R8: `rd_data` is combinational on `rd_sel`: 0 live pin levels, 1 value register, 2 direction, 3 source select, 4 open-drain, and 0 for codes 5 to 7.
- R9: `imc_in` always equals `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Read source select |
| rd_data | output | 8 | Read data |
| ale | input | 1 | Address latch enable, latch transparent while high |
| addr_lo | input | 8 | Low address byte |
| mc_here | input | 1 | Logic-output bank routed to this port |
| mc_out | input | 8 | Programmable-logic output values |
| pt_oe | input | 8 | Programmable-logic output enables |
| pin_in | input | 8 | Sensed pin levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| imc_in | output | 8 | Pin levels to logic input cells |

## Verification
A register write and a read of that same register can fall in the same cycle. The bench holds `rd_sel` on the value register, drives a write strobe for the next edge, and samples `rd_data` before and after that edge. It must see the old contents before the edge and the new ones after it. The bench also changes the address byte while the latch is open in address mode, and again after the strobe falls, to show that the pins follow the address only while the latch is transparent.

// File: rtl/cfg_io_port.sv
module cfg_io_port #(
  parameter int W     = 8,
  parameter int OD_LO = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         ale,
  input  logic [W-1:0] addr_lo,
  input  logic         mc_here,
  input  logic [W-1:0] mc_out,
  input  logic [W-1:0] pt_oe,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] imc_in
);

  localparam logic [1:0] SEL_VAL  = 2'd0;
  localparam logic [1:0] SEL_DIR  = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;
  localparam logic [1:0] SEL_OD   = 2'd3;
  localparam logic [W-1:0] OD_MASK = {W{1'b1}} << OD_LO;

  logic [W-1:0] val_q, dir_q, ctl_q, od_q, addr_q;
  logic [W-1:0] src, base_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      dir_q <= '0;
      ctl_q <= '0;
      od_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_VAL: val_q <= wr_data;
        SEL_DIR: dir_q <= wr_data;
        SEL_CTL: ctl_q <= wr_data;
        default: od_q  <= wr_data & OD_MASK;
      endcase
    end
  end

  always_latch begin
    if (rst)      addr_q = '0;
    else if (ale) addr_q = addr_lo;
  end

  assign src     = mc_here ? mc_out : ((ctl_q & addr_q) | (~ctl_q & val_q));
  assign base_oe = mc_here ? pt_oe  : (ctl_q | dir_q);
  assign imc_in  = pin_in;

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i >= OD_LO) begin : g_od
      assign pin_out[i] = od_q[i] ? 1'b0 : src[i];
      assign pin_oe[i]  = base_oe[i] & ~(od_q[i] & src[i]);
    end else begin : g_pp
      assign pin_out[i] = src[i];
      assign pin_oe[i]  = base_oe[i];
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = pin_in;
      3'd1:    rd_data = val_q;
      3'd2:    rd_data = dir_q;
      3'd3:    rd_data = ctl_q;
      3'd4:    rd_data = od_q;
      default: rd_data = '0;
    endcase
  end

  assert_wr_dir_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_DIR) |=> dir_q == $past(wr_data));

  assert_no_wr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable({val_q, dir_q, ctl_q, od_q}));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ale && !$past(ale)) |-> $stable(addr_q));

  assert_route_oe_R6: assert property (@(posedge clk) disable iff (rst)
    mc_here |-> ((pin_oe ^ pt_oe) & ~od_q) == '0);

  assert_od_release_R7: assert property (@(posedge clk) disable iff (rst)
    (!mc_here && ctl_q == '0) |-> (pin_oe & od_q & val_q) == '0);

  assert_od_low_R7: assert property (@(posedge clk) disable iff (rst)
    (od_q & ~OD_MASK) == '0);

endmodule

// File: tb/sim_cfg_io_port.sv
module sim_cfg_io_port;
  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] rd_sel = 0;
  logic [7:0] rd_data;
  logic ale = 0;
  logic [7:0] addr_lo = 0;
  logic mc_here = 0;
  logic [7:0] mc_out = 0, pt_oe = 0, pin_in = 0;
  logic [7:0] pin_out, pin_oe, imc_in;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_io_port u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ale(ale), .addr_lo(addr_lo), .mc_here(mc_here),
    .mc_out(mc_out), .pt_oe(pt_oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .imc_in(imc_in));

  typedef struct packed {
    logic [7:0] val, dir, ctl, od, addr, mc, pt;
    logic       here;
    logic [7:0] eout, eoe;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'hA5, 8'hFF, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 1'b0, 8'hA5, 8'hFF},
    '{8'hA5, 8'h0F, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 1'b0, 8'hA5, 8'h0F},
    '{8'h00, 8'h00, 8'hFF, 8'h00, 8'h3C, 8'h00, 8'h00, 1'b0, 8'h3C, 8'hFF},
    '{8'hF0, 8'hFF, 8'h0F, 8'h00, 8'h3C, 8'h00, 8'h00, 1'b0, 8'hFC, 8'hFF},
    '{8'h00, 8'h00, 8'hFF, 8'h00, 8'h3C, 8'h5A, 8'hC3, 1'b1, 8'h5A, 8'hC3},
    '{8'hA5, 8'hFF, 8'h00, 8'hFF, 8'h3C, 8'h00, 8'h00, 1'b0, 8'h05, 8'h5F},
    '{8'h00, 8'h0F, 8'h00, 8'hF0, 8'h3C, 8'h00, 8'h00, 1'b0, 8'h00, 8'h0F},
    '{8'h00, 8'h00, 8'h00, 8'hF0, 8'h3C, 8'h0F, 8'hFF, 1'b1, 8'h0F, 8'hFF}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic latch_addr(input logic [7:0] a);
    @(negedge clk); ale = 1; addr_lo = a;
    @(negedge clk); ale = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    chk("R1 pin_oe after reset", pin_oe, 8'h00);
    for (int s = 1; s <= 4; s++) begin
      rd_sel = 3'(s); #1;
      chk("R1 register reads 0 after reset", rd_data, 8'h00);
    end

    for (int k = 0; k < 8; k++) begin
      mc_here = 0;
      wr(2'd0, VEC[k].val);
      wr(2'd1, VEC[k].dir);
      wr(2'd2, VEC[k].ctl);
      wr(2'd3, VEC[k].od);
      latch_addr(VEC[k].addr);
      mc_out = VEC[k].mc; pt_oe = VEC[k].pt; mc_here = VEC[k].here;
      #1;
      chk($sformatf("R3 R4 R6 R7 vector %0d pin_out", k), pin_out, VEC[k].eout);
      chk($sformatf("R3 R4 R6 R7 vector %0d pin_oe", k), pin_oe, VEC[k].eoe);
    end
    mc_here = 0;

    wr(2'd3, 8'hFF);
    rd_sel = 3'd4; #1;
    chk("R7 od low nibble reads 0", rd_data, 8'hF0);

    wr(2'd0, 8'h3C);
    rd_sel = 3'd1;
    @(negedge clk); wr_en = 0; wr_sel = 2'd0; wr_data = 8'hFF; #1;
    @(negedge clk); #1;
    chk("R2 no write without strobe", rd_data, 8'h3C);

    @(negedge clk); wr_en = 1; wr_sel = 2'd0; wr_data = 8'h77; #1;
    chk("R2 same-cycle read shows old value", rd_data, 8'h3C);
    @(negedge clk); wr_en = 0; #1;
    chk("R2 read after edge shows new value", rd_data, 8'h77);

    pin_in = 8'h96; rd_sel = 3'd0; #1;
    chk("R8 read live pins", rd_data, 8'h96);
    chk("R9 imc_in follows pins", imc_in, 8'h96);
    pin_in = 8'h41; #1;
    chk("R9 imc_in follows new pins", imc_in, 8'h41);
    rd_sel = 3'd6; #1;
    chk("R8 unused code reads 0", rd_data, 8'h00);
    wr(2'd1, 8'h5A);
    rd_sel = 3'd2; #1;
    chk("R8 direction readback", rd_data, 8'h5A);

    wr(2'd3, 8'h00);
    wr(2'd2, 8'hFF);
    @(negedge clk); ale = 1; addr_lo = 8'h11; #1;
    chk("R5 latch transparent", pin_out, 8'h11);
    @(negedge clk); addr_lo = 8'h22; #1;
    chk("R5 latch follows while open", pin_out, 8'h22);
    @(negedge clk); ale = 0;
    @(negedge clk); addr_lo = 8'h33; #1;
    chk("R5 latch holds when closed", pin_out, 8'h22);
    chk("R4 address mode drives", pin_oe, 8'hFF);

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; rd_sel = 3'd3; #1;
    chk("R1 reset clears source select", rd_data, 8'h00);
    chk("R1 reset releases pins", pin_oe, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule